// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit maps a 32-bit effective address onto a physical address through a small set of programmable block windows, without a page table. Two banks of four windows are kept, one consulted for instruction fetches and one for every other access. Each window is a pair of 32-bit words. The upper word holds the window's address tag, a length mask and the two privilege enables. The lower word holds the physical base and the access permission.

A request is presented for one cycle with `req_vld`. One clock later the result appears with a single-cycle `rsp_vld`. The result is one of three outcomes: a hit, with the translated address and its permissions; a protection violation, when a window matches but forbids the access; or a miss. On a miss the effective address is also latched into `fault_addr`. Windows are loaded through a simple write port.

The length mask widens a window. A set mask bit removes the matching address bit from the tag compare, and that address bit is passed straight through to the physical address. This gives block sizes from 128 KiB up to 256 MiB.

Top module: `bxlat_match`

## Requirements
- R1: A request with `req_code`=1 is checked only against the code bank (`cfg_bank`=1); any other request is checked only against the data bank (`cfg_bank`=0).
- R2: A window can match only when address bits 31:28 equal upper-word bits 31:28 exactly.
- R3: Upper-word bits 12:2 form a length mask aligned to address bits 27:17. Address bits 27:17 are compared against upper-word bits 27:17 only where the mask bit is 0. A tag bit that is set under a set mask bit makes the window unable to match.
- R4: A window is usable in supervisor mode (`req_user`=0) only if upper-word bit 1 is set, and in user mode (`req_user`=1) only if upper-word bit 0 is set.
- R5: On a hit, `rsp_paddr` = {lower[31:28], (addr[27:17] AND mask) OR lower[27:17], addr[16:0]}.
- R6: Lower-word bit 1 grants read and write. Otherwise lower-word bit 0 grants read only. With neither bit set there is no access. A matching window that does not permit the access gives `rsp_prot_err`, not a miss, and reports that window's address and permissions.
- R7: When several windows match, the lowest index wins, and its index is reported on `rsp_idx`.
- R8: On a miss, `fault_addr` takes the request address. `fault_addr` changes at no other time. On a miss, `rsp_paddr`, `rsp_idx`, `rsp_rd_ok` and `rsp_wr_ok` are 0.
- R9: The result appears on the clock edge after `req_vld` is sampled, with `rsp_vld` high for exactly one cycle and exactly one of hit, miss or protection error set. The result fields hold their values while no request is made.
- R10: After reset all window words are 0, so every request misses. `rsp_vld` is 0 and `fault_addr` is 0.
- R11: A window write takes effect for requests sampled after its write edge. A request sampled on the same edge as a write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Translation request strobe |
| req_addr | input | 32 | Effective address |
| req_code | input | 1 | 1 = instruction fetch |
| req_wr | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| cfg_we | input | 1 | Window word write enable |
| cfg_bank | input | 1 | 1 = code bank, 0 = data bank |
| cfg_idx | input | 2 | Window index |
| cfg_upper | input | 1 | 1 = upper word, 0 = lower word |
| cfg_data | input | 32 | Word to write |
| rsp_vld | output | 1 | Result strobe |
| rsp_hit | output | 1 | Window matched and access allowed |
| rsp_miss | output | 1 | No usable window matched |
| rsp_prot_err | output | 1 | Window matched, access forbidden |
| rsp_paddr | output | 32 | Physical address |
| rsp_rd_ok | output | 1 | Selected window permits reads |
| rsp_wr_ok | output | 1 | Selected window permits writes |
| rsp_idx | output | 2 | Index of the selected window |
| fault_addr | output | 32 | Address of the last miss |

## Verification
The hardest case to reach is an address that matches a window only because of its mask, while a lower-indexed window also covers it under a different mask and privilege setting. Purely random addresses almost never land inside a window. The random phase therefore draws tags, masks and address block bits from a narrow range, so windows overlap often and masked pass-through bits vary. Directed cases cover a tag bit set under the mask, a request issued on the same edge as a window write, and both no-permission encodings.

// File: rtl/bxlat_pkg.sv
package bxlat_pkg;
   // bank selector encoding on the write port and request side
   localparam logic BANK_DATA = 1'b0;
   localparam logic BANK_CODE = 1'b1;

   // privilege enable bit positions in the upper word
   localparam int SUP_EN_BIT = 1;
   localparam int USR_EN_BIT = 0;

   // permission bit positions in the lower word
   localparam int PERM_RO_BIT = 0;
   localparam int PERM_RW_BIT = 1;

   typedef enum logic [1:0] {
      OUT_MISS = 2'd0,
      OUT_HIT  = 2'd1,
      OUT_PROT = 2'd2
   } outcome_e;

   function automatic logic access_allowed(input logic wr, input logic rd_ok,
                                           input logic wr_ok);
      return wr ? wr_ok : rd_ok;
   endfunction
endpackage

// File: rtl/bxlat_regfile.sv
module bxlat_regfile #(
   parameter int ADDR_W  = 32,
   parameter int NUM_ENT = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic                         wr_bank,
   input  logic [$clog2(NUM_ENT)-1:0]   wr_idx,
   input  logic                         wr_upper,
   input  logic [ADDR_W-1:0]            wr_data,
   input  logic                         rd_bank,
   output logic [NUM_ENT*ADDR_W-1:0]    upper_flat,
   output logic [NUM_ENT*ADDR_W-1:0]    lower_flat
);
   localparam int IDX_W   = $clog2(NUM_ENT);
   localparam int N_BANKS = 2;

   logic [NUM_ENT*ADDR_W-1:0] bank_up [N_BANKS];
   logic [NUM_ENT*ADDR_W-1:0] bank_lo [N_BANKS];

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
         logic [ADDR_W-1:0] up_q;
         logic [ADDR_W-1:0] lo_q;
         logic              sel;

         assign sel = wr_en && (wr_bank == 1'(b)) && (wr_idx == IDX_W'(e));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               up_q <= '0;
               lo_q <= '0;
            end else if (sel) begin
               if (wr_upper) up_q <= wr_data;
               else          lo_q <= wr_data;
            end
         end

         assign bank_up[b][e*ADDR_W +: ADDR_W] = up_q;
         assign bank_lo[b][e*ADDR_W +: ADDR_W] = lo_q;
      end
   end

   assign upper_flat = bank_up[rd_bank];
   assign lower_flat = bank_lo[rd_bank];
endmodule

// File: rtl/bxlat_entry.sv
module bxlat_entry
   import bxlat_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int HI_W     = 4,
   parameter int BLK_W    = 11,
   parameter int MASK_LSB = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              user,
   input  logic [ADDR_W-1:0] upper,
   input  logic [ADDR_W-1:0] lower,
   output logic              match,
   output logic [ADDR_W-1:0] paddr,
   output logic              rd_ok,
   output logic              wr_ok
);
   localparam int OFF_W   = ADDR_W - HI_W - BLK_W;
   localparam int BLK_LSB = OFF_W;
   localparam int HI_LSB  = ADDR_W - HI_W;

   logic [BLK_W-1:0] len_mask;
   logic [BLK_W-1:0] addr_blk;
   logic             hi_eq;
   logic             blk_eq;
   logic             priv_ok;

   assign len_mask = upper[MASK_LSB +: BLK_W];
   assign addr_blk = addr[BLK_LSB +: BLK_W];
   assign hi_eq    = addr[HI_LSB +: HI_W] == upper[HI_LSB +: HI_W];
   assign blk_eq   = (addr_blk & ~len_mask) == upper[BLK_LSB +: BLK_W];
   assign priv_ok  = user ? upper[USR_EN_BIT] : upper[SUP_EN_BIT];
   assign match    = hi_eq && blk_eq && priv_ok;

   assign paddr = {lower[HI_LSB +: HI_W],
                   (addr_blk & len_mask) | lower[BLK_LSB +: BLK_W],
                   addr[OFF_W-1:0]};

   assign wr_ok = lower[PERM_RW_BIT];
   assign rd_ok = lower[PERM_RW_BIT] | lower[PERM_RO_BIT];

   logic unused_fields;
   assign unused_fields = ^{upper[BLK_LSB-1:MASK_LSB+BLK_W],
                            lower[BLK_LSB-1:PERM_RW_BIT+1]};
endmodule

// File: rtl/bxlat_first_sel.sv
module bxlat_first_sel #(
   parameter int ADDR_W  = 32,
   parameter int NUM_ENT = 4
) (
   input  logic [NUM_ENT-1:0]          hit_vec,
   input  logic [NUM_ENT*ADDR_W-1:0]   paddr_flat,
   input  logic [NUM_ENT-1:0]          rd_vec,
   input  logic [NUM_ENT-1:0]          wr_vec,
   output logic                        any,
   output logic [$clog2(NUM_ENT)-1:0]  idx,
   output logic [ADDR_W-1:0]           paddr,
   output logic                        rd_ok,
   output logic                        wr_ok
);
   localparam int IDX_W = $clog2(NUM_ENT);

   always_comb begin
      idx = '0;
      for (int i = NUM_ENT - 1; i >= 0; i--) begin
         if (hit_vec[i]) idx = IDX_W'(i);
      end
   end

   assign any   = |hit_vec;
   assign paddr = paddr_flat[int'(idx)*ADDR_W +: ADDR_W];
   assign rd_ok = rd_vec[idx];
   assign wr_ok = wr_vec[idx];
endmodule

// File: rtl/bxlat_match.sv
module bxlat_match
   import bxlat_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int NUM_ENT  = 4,
   parameter int HI_W     = 4,
   parameter int BLK_W    = 11,
   parameter int MASK_LSB = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_vld,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic                        req_code,
   input  logic                        req_wr,
   input  logic                        req_user,
   input  logic                        cfg_we,
   input  logic                        cfg_bank,
   input  logic [$clog2(NUM_ENT)-1:0]  cfg_idx,
   input  logic                        cfg_upper,
   input  logic [ADDR_W-1:0]           cfg_data,
   output logic                        rsp_vld,
   output logic                        rsp_hit,
   output logic                        rsp_miss,
   output logic                        rsp_prot_err,
   output logic [ADDR_W-1:0]           rsp_paddr,
   output logic                        rsp_rd_ok,
   output logic                        rsp_wr_ok,
   output logic [$clog2(NUM_ENT)-1:0]  rsp_idx,
   output logic [ADDR_W-1:0]           fault_addr
);
   localparam int IDX_W = $clog2(NUM_ENT);
   localparam int OFF_W = ADDR_W - HI_W - BLK_W;

   // elaboration-time parameter checks
   if (NUM_ENT < 2) begin : g_bad_ent
      $error("bxlat_match: NUM_ENT must be at least 2");
   end
   if (OFF_W < 1) begin : g_bad_split
      $error("bxlat_match: HI_W + BLK_W must leave an offset field");
   end
   if (MASK_LSB < 2 || MASK_LSB + BLK_W > OFF_W) begin : g_bad_mask
      $error("bxlat_match: length mask field overlaps another field");
   end

   logic [NUM_ENT*ADDR_W-1:0] upper_flat;
   logic [NUM_ENT*ADDR_W-1:0] lower_flat;
   logic [NUM_ENT*ADDR_W-1:0] paddr_flat;
   logic [NUM_ENT-1:0]        hit_vec;
   logic [NUM_ENT-1:0]        rd_vec;
   logic [NUM_ENT-1:0]        wr_vec;

   bxlat_regfile #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_bank   (cfg_bank),
      .wr_idx    (cfg_idx),
      .wr_upper  (cfg_upper),
      .wr_data   (cfg_data),
      .rd_bank   (req_code ? BANK_CODE : BANK_DATA),
      .upper_flat(upper_flat),
      .lower_flat(lower_flat)
   );

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_win
      bxlat_entry #(
         .ADDR_W(ADDR_W), .HI_W(HI_W), .BLK_W(BLK_W), .MASK_LSB(MASK_LSB)
      ) u_ent (
         .addr (req_addr),
         .user (req_user),
         .upper(upper_flat[e*ADDR_W +: ADDR_W]),
         .lower(lower_flat[e*ADDR_W +: ADDR_W]),
         .match(hit_vec[e]),
         .paddr(paddr_flat[e*ADDR_W +: ADDR_W]),
         .rd_ok(rd_vec[e]),
         .wr_ok(wr_vec[e])
      );
   end

   logic              sel_any;
   logic [IDX_W-1:0]  sel_idx;
   logic [ADDR_W-1:0] sel_paddr;
   logic              sel_rd;
   logic              sel_wr;

   bxlat_first_sel #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT)) u_sel (
      .hit_vec   (hit_vec),
      .paddr_flat(paddr_flat),
      .rd_vec    (rd_vec),
      .wr_vec    (wr_vec),
      .any       (sel_any),
      .idx       (sel_idx),
      .paddr     (sel_paddr),
      .rd_ok     (sel_rd),
      .wr_ok     (sel_wr)
   );

   outcome_e nxt_out;
   always_comb begin
      if (!sel_any)                                   nxt_out = OUT_MISS;
      else if (access_allowed(req_wr, sel_rd, sel_wr)) nxt_out = OUT_HIT;
      else                                            nxt_out = OUT_PROT;
   end

   outcome_e out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld    <= 1'b0;
         out_q      <= OUT_MISS;
         rsp_paddr  <= '0;
         rsp_rd_ok  <= 1'b0;
         rsp_wr_ok  <= 1'b0;
         rsp_idx    <= '0;
         fault_addr <= '0;
      end else begin
         rsp_vld <= req_vld;
         if (req_vld) begin
            out_q <= nxt_out;
            if (nxt_out == OUT_MISS) begin
               rsp_paddr  <= '0;
               rsp_rd_ok  <= 1'b0;
               rsp_wr_ok  <= 1'b0;
               rsp_idx    <= '0;
               fault_addr <= req_addr;
            end else begin
               rsp_paddr <= sel_paddr;
               rsp_rd_ok <= sel_rd;
               rsp_wr_ok <= sel_wr;
               rsp_idx   <= sel_idx;
            end
         end
      end
   end

   assign rsp_hit      = out_q == OUT_HIT;
   assign rsp_miss     = out_q == OUT_MISS;
   assign rsp_prot_err = out_q == OUT_PROT;
endmodule

// File: rtl/bxlat_match_chk.sv
module bxlat_match_chk #(
   parameter int ADDR_W = 32,
   parameter int HI_W   = 4,
   parameter int BLK_W  = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_wr,
   input logic              rsp_vld,
   input logic              rsp_hit,
   input logic              rsp_miss,
   input logic              rsp_prot_err,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic              rsp_rd_ok,
   input logic              rsp_wr_ok,
   input logic [ADDR_W-1:0] fault_addr
);
   localparam int OFF_W = ADDR_W - HI_W - BLK_W;

   p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);

   p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_vld);

   p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> $countones({rsp_hit, rsp_miss, rsp_prot_err}) == 1);

   p_fault_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_miss) |-> fault_addr == $past(req_addr));

   p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_vld && rsp_miss) |-> $stable(fault_addr));

   p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_hit) |-> rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));

   p_hit_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_hit) |-> ($past(req_wr) ? rsp_wr_ok : rsp_rd_ok));

   p_prot_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_prot_err) |-> !($past(req_wr) ? rsp_wr_ok : rsp_rd_ok));
endmodule

bind bxlat_match bxlat_match_chk #(
   .ADDR_W(ADDR_W), .HI_W(HI_W), .BLK_W(BLK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
   .req_wr(req_wr), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit),
   .rsp_miss(rsp_miss), .rsp_prot_err(rsp_prot_err), .rsp_paddr(rsp_paddr),
   .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok), .fault_addr(fault_addr)
);

// File: tb/bxlat_match_test.sv
`timescale 1ns/1ps
module bxlat_match_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0, req_code = 1'b0, req_wr = 1'b0, req_user = 1'b0;
   logic [31:0] req_addr = '0;
   logic        cfg_we = 1'b0, cfg_bank = 1'b0, cfg_upper = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [31:0] cfg_data = '0;
   logic        rsp_vld, rsp_hit, rsp_miss, rsp_prot_err, rsp_rd_ok, rsp_wr_ok;
   logic [31:0] rsp_paddr, fault_addr;
   logic [1:0]  rsp_idx;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   logic [31:0] m_up [2][4];
   logic [31:0] m_lo [2][4];
   logic [31:0] m_fault = '0;
   logic [38:0] last_res = '0;

   always #4 clk = ~clk;

   bxlat_match uut (.*);

   // expected: {hit, miss, prot, rd, wr, idx[1:0], paddr[31:0]}
   function automatic logic [38:0] predict(input logic [31:0] a, input logic code,
                                           input logic wr, input logic user);
      for (int i = 0; i < 4; i++) begin
         logic [31:0] u, l;
         logic [10:0] mk;
         logic        rd, wk, ok;
         u  = m_up[code][i];
         l  = m_lo[code][i];
         mk = u[12:2];
         if (a[31:28] == u[31:28] && ((a[27:17] & ~mk) == u[27:17]) &&
             (user ? u[0] : u[1])) begin
            wk = l[1];
            rd = l[1] | l[0];
            ok = wr ? wk : rd;
            return {ok, 1'b0, !ok, rd, wk, 2'(i),
                    l[31:28], (a[27:17] & mk) | l[27:17], a[16:0]};
         end
      end
      return {1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 32'h0};
   endfunction

   task automatic put(input logic bank, input int idx, input logic up, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_bank = bank; cfg_idx = 2'(idx); cfg_upper = up; cfg_data = d;
      @(negedge clk);
      cfg_we = 0;
      if (up) m_up[bank][idx] = d; else m_lo[bank][idx] = d;
   endtask

   task automatic check_res(input string tag, input logic [38:0] exp_v);
      logic [38:0] act;
      act = {rsp_hit, rsp_miss, rsp_prot_err, rsp_rd_ok, rsp_wr_ok, rsp_idx, rsp_paddr};
      n_vec++;
      if (!rsp_vld || act !== exp_v || fault_addr !== m_fault) begin
         n_bad++;
         $display("FAIL %s: vld=%b res=%h fault=%h expected vld=1 res=%h fault=%h",
                  tag, rsp_vld, act, fault_addr, exp_v, m_fault);
      end
      last_res = act;
   endtask

   task automatic req(input string tag, input logic [31:0] a, input logic code,
                      input logic wr, input logic user);
      logic [38:0] e;
      e = predict(a, code, wr, user);
      @(negedge clk);
      req_vld = 1; req_addr = a; req_code = code; req_wr = wr; req_user = user;
      @(negedge clk);
      req_vld = 0;
      if (e[37]) m_fault = a;
      check_res(tag, e);
   endtask

   initial begin
      int seed;
      logic [10:0] masks [5];
      seed = $urandom(32'h0BA7_5EED);
      masks = '{11'h000, 11'h001, 11'h003, 11'h007, 11'h7FF};
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 4; i++) begin m_up[b][i] = '0; m_lo[b][i] = '0; end
      repeat (3) @(negedge clk);
      // R10: reset state
      n_vec++;
      if (rsp_vld !== 1'b0 || fault_addr !== 32'h0) begin
         n_bad++;
         $display("FAIL R10 reset: vld=%b fault=%h expected vld=0 fault=0", rsp_vld, fault_addr);
      end
      rst_n = 1;
      req("R10 empty windows miss", 32'h0000_1234, 0, 0, 0);
      req("R10 empty code bank miss", 32'hFFFF_FFFF, 1, 1, 1);

      // data window 0: region 8, tag 0x005, no mask, supervisor only, rw
      put(0, 0, 1, 32'h800A_0002);
      put(0, 0, 0, 32'h3200_0002);
      req("R5 exact hit address", 32'h800A_4321, 0, 0, 0);
      req("R6 rw write hit", 32'h800B_FFFF, 0, 1, 0);
      req("R2 region differs", 32'h900A_4321, 0, 0, 0);
      req("R4 user blocked", 32'h800A_4321, 0, 0, 1);
      req("R1 code bank empty", 32'h800A_4321, 1, 0, 0);

      // R9: hold while idle
      repeat (3) @(negedge clk);
      n_vec++;
      if (rsp_vld !== 1'b0 ||
          {rsp_hit, rsp_miss, rsp_prot_err, rsp_rd_ok, rsp_wr_ok, rsp_idx, rsp_paddr} !== last_res) begin
         n_bad++;
         $display("FAIL R9 hold: vld=%b res=%h expected vld=0 res=%h", rsp_vld,
                  {rsp_hit, rsp_miss, rsp_prot_err, rsp_rd_ok, rsp_wr_ok, rsp_idx, rsp_paddr}, last_res);
      end

      // data window 1: region 4, tag 0x010, mask 0x00F, both modes, read only
      put(0, 1, 1, 32'h4000_0000 | (32'h010 << 17) | (32'h00F << 2) | 32'h3);
      put(0, 1, 0, 32'h7000_0000 | (32'h400 << 17) | 32'h1);
      req("R3 masked bits pass through", 32'h4000_0055 | (32'h01A << 17), 0, 0, 1);
      req("R3 bit outside mask differs", 32'h4000_0055 | (32'h02A << 17), 0, 0, 0);
      req("R6 write to read-only", 32'h4000_0000 | (32'h01F << 17), 0, 1, 0);

      // data window 2: tag bit under mask never matches
      put(0, 2, 1, 32'h5000_0000 | (32'h003 << 17) | (32'h001 << 2) | 32'h3);
      put(0, 2, 0, 32'h0000_0002);
      req("R3 tag under mask a", 32'h5000_0000 | (32'h003 << 17), 0, 0, 0);
      req("R3 tag under mask b", 32'h5000_0000 | (32'h002 << 17), 0, 0, 0);

      // data window 3: no permission
      put(0, 3, 1, 32'hA000_0003);
      put(0, 3, 0, 32'hB000_0000);
      req("R6 no permission read", 32'hA001_0000, 0, 0, 0);

      // priority: window 2 overlaps window 0 and is user-enabled
      put(0, 2, 1, 32'h800A_0003);
      put(0, 2, 0, 32'hC000_0001);
      req("R7 lowest index wins", 32'h800A_0010, 0, 0, 0);
      req("R7 next index when 0 unusable", 32'h800A_0010, 0, 0, 1);

      // code bank window 0 same tag, different physical
      put(1, 0, 1, 32'h800A_0002);
      put(1, 0, 0, 32'h1000_0001);
      req("R1 code bank used", 32'h800A_0100, 1, 0, 0);
      req("R1 data bank for non-code", 32'h800A_0100, 0, 0, 0);

      // R11: request on the same edge as a write sees old contents
      begin
         logic [38:0] e_old;
         e_old = predict(32'h800A_0200, 0, 0, 0);
         @(negedge clk);
         req_vld = 1; req_addr = 32'h800A_0200; req_code = 0; req_wr = 0; req_user = 0;
         cfg_we = 1; cfg_bank = 0; cfg_idx = 0; cfg_upper = 1; cfg_data = 32'h0;
         @(negedge clk);
         req_vld = 0; cfg_we = 0;
         m_up[0][0] = 32'h0;
         check_res("R11 same edge write old contents", e_old);
         req("R11 write visible after", 32'h800A_0200, 0, 0, 0);
      end

      // random phase: narrow ranges so windows overlap
      for (int k = 0; k < 400; k++) begin
         if (k % 50 == 0) begin
            for (int b = 0; b < 2; b++)
               for (int i = 0; i < 4; i++) begin
                  logic [10:0] mk, tg;
                  mk = masks[$urandom % 5];
                  tg = 11'($urandom & 32'h7) & ~mk;
                  put(b[0], i, 1, {4'($urandom % 3), tg, 4'h0, mk, 2'($urandom)});
                  put(b[0], i, 0, $urandom & 32'hFFFE_0003);
               end
         end
         req("R5 random", {4'($urandom % 3), 11'($urandom & 32'hF), 17'($urandom)},
             1'($urandom), 1'($urandom), 1'($urandom));
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule